// File: doc/BRIEF.md
# Per-CPU Interrupt Mapper

This block steers 128 level-sensitive interrupt sources onto a handful of interrupt output lines for each of four processors. Every processor owns a private bank of registers: a mask pair, a pending-status pair, a link-pending pair with write-one-to-clear ports, one routing (map) register per source, and two mailboxes. A source reaches an output line of a processor only when it is raised, when that processor's mask leaves it enabled, and when that processor's map register for it picks that line.

Software drives the block over a plain 64-bit register bus. Reads return data one cycle after the request. Sources 0 to 63 form the "upper" half and sources 64 to 127 the "lower" half. Each lower-half register sits 0x400 above its upper-half partner. Bit 0 of the upper half is not a real source. In the upper status word it reports that something is pending in the lower half, so a handler can scan the upper word from its highest set bit down and only then turn to the lower word. Mailbox 0 of a processor feeds one routable source (index `MBOX_SRC`, 26 by default), so one processor can interrupt another.

Top module: `imap_top`

## Requirements
- R1: Byte address bits [13:12] select the processor bank. Bits [2:0] are ignored. A write changes only the bank it addresses.
- R2: After reset every mask bit is 1, every map register is 0, and link-pending bits and mailboxes are 0. No output line is asserted and no read is valid.
- R3: Mask words sit at offset 0x000 (sources 0–63) and 0x400 (sources 64–127) and read back as written. A mask bit of 1 disables its source for that processor and a 0 enables it. With every real source masked, a processor drives no line.
- R4: The status words (0x008 upper, 0x408 lower) show bit n = raw n AND NOT mask n. Here raw n = source input n OR link-pending n, and raw `MBOX_SRC` also goes high while mailbox 0 is nonzero. Status is taken in the cycle of the read request.
- R5: The map register of source n is at 0x200 + 8·n for n < 64 and at 0x600 + 8·(n−64) for n ≥ 64. Its bits [2:0] are stored and read back zero-extended. Codes 0–4 select output line 0–4, and codes 5–7 route the source nowhere.
- R6: Source input 0 is ignored. Bit 0 of the upper status word is 1 exactly when any lower-half status bit is 1.
- R7: Output line k of processor c (`irq_o[c*5+k]`) is the OR of the status bits of sources 1–127 whose map code is k. It is level-sensitive and follows the status in the same cycle.
- R8: A pulse on `link_set_i[n]` sets link-pending bit n in every bank (read at 0x010/0x410). Writing to 0x018/0x418 clears the pending bits where the data is 1 and leaves bits where the data is 0. A set in the same cycle as a clear wins.
- R9: Mailbox 0 reads at 0x800, is ORed by writes to 0x808, and is cleared bitwise by 1s written to 0x810. Mailbox 1 uses 0x818, 0x820 and 0x828 the same way. Writing all ones to a clear port empties the mailbox.
- R10: Reads of any other address return zero, and writes to them change nothing. The status and link-pending words are read-only, and the clear and set ports read as zero.
- R11: `rsp_valid_o` is high exactly in the cycle after `req_rd_i`, with `rsp_rdata_o` holding the word requested. A read and a write in the same cycle return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | 128 | Level interrupt sources, bit n is source n |
| link_set_i | input | 128 | One-cycle pulses that set link-pending bits in all banks |
| req_addr_i | input | 14 | Byte address: bank in [13:12], offset in [11:0] |
| req_wr_i | input | 1 | Write strobe |
| req_rd_i | input | 1 | Read strobe |
| req_wdata_i | input | 64 | Write data |
| rsp_valid_o | output | 1 | Read data valid, one cycle after the request |
| rsp_rdata_o | output | 64 | Read data |
| irq_o | output | 20 | Output lines, bit c*5+k is line k of processor c |

## Verification
The embedded properties check the following on every cycle:
- a mask word changes only when it is written;
- a link-pending clear leaves no written-1 bit set unless a set pulse arrived with it;
- an all-ones mailbox clear empties the mailbox;
- read valid trails the request by exactly one cycle;
- a fully masked processor keeps all its lines low.

Other behaviour shows up only through the bench's scenarios, which compare against a behavioural model every cycle. These are:
- routing by map code, including the codes that route nowhere;
- the lower-half summary in upper status bit 0 and the ignored source 0;
- mailbox 0 reaching its routable source;
- bank isolation;
- set-over-clear precedence;
- silence of unmapped addresses.

// File: rtl/imap_pkg.sv
package imap_pkg;

    localparam int DW = 64;

    // Decoded view of a 12-bit byte offset inside one processor bank
    typedef struct packed {
        logic       is_mask;
        logic       is_stat;
        logic       is_lpend;
        logic       is_lclr;
        logic       is_map;
        logic       is_mb0;
        logic       is_mb0_set;
        logic       is_mb0_clr;
        logic       is_mb1;
        logic       is_mb1_set;
        logic       is_mb1_clr;
        logic       half;
        logic [5:0] idx;
    } dec_t;

    function automatic dec_t decode(input logic [11:0] off);
        dec_t d;
        d      = '0;
        d.half = off[10];
        d.idx  = off[8:3];
        if (!off[11]) begin
            if (off[9]) begin
                d.is_map = 1'b1;
            end else if (off[8:5] == 4'd0) begin
                case (off[4:3])
                    2'd0:    d.is_mask  = 1'b1;
                    2'd1:    d.is_stat  = 1'b1;
                    2'd2:    d.is_lpend = 1'b1;
                    default: d.is_lclr  = 1'b1;
                endcase
            end
        end else if (!off[10] && off[9:6] == 4'd0) begin
            case (off[5:3])
                3'd0:    d.is_mb0     = 1'b1;
                3'd1:    d.is_mb0_set = 1'b1;
                3'd2:    d.is_mb0_clr = 1'b1;
                3'd3:    d.is_mb1     = 1'b1;
                3'd4:    d.is_mb1_set = 1'b1;
                3'd5:    d.is_mb1_clr = 1'b1;
                default: ;
            endcase
        end
        return d;
    endfunction

endpackage

// File: rtl/imap_route.sv
module imap_route
    import imap_pkg::*;
#(
    parameter int NSRC     = 128,
    parameter int NLINE    = 5,
    parameter int MBOX_SRC = 26,
    localparam int MW      = (NLINE > 1) ? $clog2(NLINE) : 1,
    localparam int HALF    = NSRC / 2
) (
    input  logic [NSRC-1:0]    src_i,
    input  logic [NSRC-1:0]    lpend_i,
    input  logic               mb0_any_i,
    input  logic [NSRC-1:0]    mask_i,
    input  logic [NSRC*MW-1:0] map_i,
    output logic [NSRC-1:0]    stat_reg_o,
    output logic [NLINE-1:0]   line_o
);

    logic [NSRC-1:0] raw;
    logic [NSRC-1:0] stat;

    always_comb begin
        raw           = src_i | lpend_i;
        raw[MBOX_SRC] = raw[MBOX_SRC] | mb0_any_i;
        raw[0]        = 1'b0;
        stat          = raw & ~mask_i;
    end

    // Register view: upper bit 0 summarises the lower half
    always_comb begin
        stat_reg_o    = stat;
        stat_reg_o[0] = |stat[NSRC-1:HALF];
    end

    always_comb begin
        line_o = '0;
        for (int k = 0; k < NLINE; k++) begin
            for (int n = 1; n < NSRC; n++) begin
                if (stat[n] && int'(map_i[n*MW +: MW]) == k) begin
                    line_o[k] = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/imap_bank.sv
module imap_bank
    import imap_pkg::*;
#(
    parameter int NSRC  = 128,
    parameter int NLINE = 5,
    localparam int MW   = (NLINE > 1) ? $clog2(NLINE) : 1,
    localparam int HALF = NSRC / 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_i,
    input  logic [11:0]        off_i,
    input  logic [DW-1:0]      wdata_i,
    input  logic [NSRC-1:0]    link_set_i,
    input  logic [NSRC-1:0]    stat_reg_i,
    output logic [NSRC-1:0]    mask_o,
    output logic [NSRC-1:0]    lpend_o,
    output logic               mb0_any_o,
    output logic [NSRC*MW-1:0] map_o,
    output logic [DW-1:0]      rdata_o
);

    typedef struct packed {
        logic [NSRC-1:0]    mask;
        logic [NSRC-1:0]    lpend;
        logic [DW-1:0]      mb0;
        logic [DW-1:0]      mb1;
        logic [NSRC*MW-1:0] map;
    } bank_t;

    bank_t s_d, s_q;
    dec_t  dec;
    int    base;
    int    sel;

    always_comb begin
        dec  = decode(off_i);
        base = dec.half ? HALF : 0;
        sel  = base + int'(dec.idx);
    end

    always_comb begin
        s_d = s_q;
        if (wr_i) begin
            if (dec.is_mask)    s_d.mask[base +: HALF]  = wdata_i;
            if (dec.is_lclr)    s_d.lpend[base +: HALF] = s_q.lpend[base +: HALF] & ~wdata_i;
            if (dec.is_map)     s_d.map[sel*MW +: MW]   = wdata_i[MW-1:0];
            if (dec.is_mb0_set) s_d.mb0 = s_q.mb0 | wdata_i;
            if (dec.is_mb0_clr) s_d.mb0 = s_q.mb0 & ~wdata_i;
            if (dec.is_mb1_set) s_d.mb1 = s_q.mb1 | wdata_i;
            if (dec.is_mb1_clr) s_d.mb1 = s_q.mb1 & ~wdata_i;
        end
        s_d.lpend = s_d.lpend | link_set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.mask <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (dec.is_mask)  rdata_o = s_q.mask[base +: HALF];
        if (dec.is_stat)  rdata_o = stat_reg_i[base +: HALF];
        if (dec.is_lpend) rdata_o = s_q.lpend[base +: HALF];
        if (dec.is_map)   rdata_o[MW-1:0] = s_q.map[sel*MW +: MW];
        if (dec.is_mb0)   rdata_o = s_q.mb0;
        if (dec.is_mb1)   rdata_o = s_q.mb1;
    end

    assign mask_o    = s_q.mask;
    assign lpend_o   = s_q.lpend;
    assign mb0_any_o = |s_q.mb0;
    assign map_o     = s_q.map;

    // R3: mask words move only on a mask write
    assert_mask_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_i && dec.is_mask) |=> $stable(s_q.mask));

    // R8: written ones are cleared unless a set pulse came with them
    assert_lclr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && dec.is_lclr && !dec.half) |=>
        ((s_q.lpend[HALF-1:0] & $past(wdata_i & ~link_set_i[HALF-1:0])) == '0));

    // R9: an all-ones clear empties mailbox 0
    assert_mbox_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && dec.is_mb0_clr && (&wdata_i)) |=> (s_q.mb0 == '0));

endmodule

// File: rtl/imap_top.sv
module imap_top
    import imap_pkg::*;
#(
    parameter int NCPU     = 4,
    parameter int NSRC     = 128,
    parameter int NLINE    = 5,
    parameter int MBOX_SRC = 26,
    localparam int BB      = (NCPU > 1) ? $clog2(NCPU) : 1,
    localparam int AW      = 12 + BB,
    localparam int MW      = (NLINE > 1) ? $clog2(NLINE) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NSRC-1:0]       src_i,
    input  logic [NSRC-1:0]       link_set_i,
    input  logic [AW-1:0]         req_addr_i,
    input  logic                  req_wr_i,
    input  logic                  req_rd_i,
    input  logic [DW-1:0]         req_wdata_i,
    output logic                  rsp_valid_o,
    output logic [DW-1:0]         rsp_rdata_o,
    output logic [NCPU*NLINE-1:0] irq_o
);

    typedef struct packed {
        logic          valid;
        logic [DW-1:0] data;
    } rsp_t;

    logic [BB-1:0] bank_sel;
    logic [DW-1:0] bank_rd [NCPU];
    rsp_t          rsp_d, rsp_q;

    assign bank_sel = req_addr_i[AW-1:12];

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        logic [NSRC-1:0]    mask_w, lpend_w, stat_w;
        logic [NSRC*MW-1:0] map_w;
        logic               mb0_w;
        logic [NLINE-1:0]   line_w;

        imap_bank #(.NSRC(NSRC), .NLINE(NLINE)) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_i       (req_wr_i && (bank_sel == BB'(c))),
            .off_i      (req_addr_i[11:0]),
            .wdata_i    (req_wdata_i),
            .link_set_i (link_set_i),
            .stat_reg_i (stat_w),
            .mask_o     (mask_w),
            .lpend_o    (lpend_w),
            .mb0_any_o  (mb0_w),
            .map_o      (map_w),
            .rdata_o    (bank_rd[c])
        );

        imap_route #(.NSRC(NSRC), .NLINE(NLINE), .MBOX_SRC(MBOX_SRC)) u_route (
            .src_i      (src_i),
            .lpend_i    (lpend_w),
            .mb0_any_i  (mb0_w),
            .mask_i     (mask_w),
            .map_i      (map_w),
            .stat_reg_o (stat_w),
            .line_o     (line_w)
        );

        assign irq_o[c*NLINE +: NLINE] = line_w;

        // R3: a processor with every real source masked stays quiet
        assert_allmask_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (&mask_w[NSRC-1:1]) |-> (line_w == '0));
    end

    always_comb begin
        rsp_d       = rsp_q;
        rsp_d.valid = req_rd_i;
        if (req_rd_i) rsp_d.data = bank_rd[bank_sel];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid_o = rsp_q.valid;
    assign rsp_rdata_o = rsp_q.data;

    // R11: response valid trails each read request by one cycle
    assert_rvalid_R11: assert property (@(posedge clk) disable iff (!rst_n)
        req_rd_i |=> rsp_valid_o);
    assert_no_rvalid_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_rd_i |=> !rsp_valid_o);

endmodule

// File: tb/sim_imap_top.sv
`timescale 1ns/1ps
module sim_imap_top;

    localparam int NC = 4;
    localparam int NS = 128;
    localparam int NL = 5;
    localparam int MBS = 26;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] src_i = '0;
    logic [NS-1:0] link_set_i = '0;
    logic [13:0]   req_addr_i = '0;
    logic          req_wr_i = 1'b0;
    logic          req_rd_i = 1'b0;
    logic [63:0]   req_wdata_i = '0;
    logic          rsp_valid_o;
    logic [63:0]   rsp_rdata_o;
    logic [NC*NL-1:0] irq_o;

    always #10 clk = ~clk;

    imap_top u0 (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .link_set_i(link_set_i),
        .req_addr_i(req_addr_i), .req_wr_i(req_wr_i), .req_rd_i(req_rd_i),
        .req_wdata_i(req_wdata_i), .rsp_valid_o(rsp_valid_o),
        .rsp_rdata_o(rsp_rdata_o), .irq_o(irq_o)
    );

    int checks = 0;
    int errors = 0;
    string phase_tag = "";

    // behavioural reference model
    bit [127:0] m_mask [NC];
    bit [127:0] m_lp [NC];
    bit [63:0]  m_mb0 [NC];
    bit [63:0]  m_mb1 [NC];
    int         m_map [NC][NS];
    bit         m_rv;
    bit [63:0]  m_rd;
    string      m_tag;

    function automatic bit [127:0] m_stat(int c);
        bit [127:0] raw;
        raw = src_i | m_lp[c];
        if (m_mb0[c] != 0) raw[MBS] = 1'b1;
        raw[0] = 1'b0;
        return raw & ~m_mask[c];
    endfunction

    function automatic bit [63:0] m_read(int a, output string tg);
        int c, off, half, o;
        bit [127:0] st;
        bit [63:0] v;
        c = a / 4096; off = (a % 4096) & ~7; v = '0; tg = "R10";
        if (off < 2048) begin
            half = off / 1024; o = off % 1024; st = m_stat(c);
            if (o == 0)  begin v = m_mask[c][half*64 +: 64]; tg = "R3"; end
            if (o == 8)  begin v = st[half*64 +: 64]; if (half == 0) v[0] = |st[127:64]; tg = "R4"; end
            if (o == 16) begin v = m_lp[c][half*64 +: 64]; tg = "R8"; end
            if (o >= 512) begin v = 64'(m_map[c][(o-512)/8 + half*64]); tg = "R5"; end
        end else if (off == 2048) begin v = m_mb0[c]; tg = "R9"; end
        else if (off == 2048 + 24) begin v = m_mb1[c]; tg = "R9"; end
        return v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NC; c++) begin
                m_mask[c] = '1; m_lp[c] = '0; m_mb0[c] = '0; m_mb1[c] = '0;
                for (int n = 0; n < NS; n++) m_map[c][n] = 0;
            end
            m_rv = 1'b0;
        end else begin
            int a, c, off, half, o;
            string tg;
            m_rv = req_rd_i;
            if (req_rd_i) begin
                m_rd = m_read(int'(req_addr_i), tg);
                m_tag = (phase_tag != "") ? phase_tag : tg;
            end
            if (req_wr_i) begin
                a = int'(req_addr_i); c = a / 4096; off = (a % 4096) & ~7;
                if (off < 2048) begin
                    half = off / 1024; o = off % 1024;
                    if (o == 0)  m_mask[c][half*64 +: 64] = req_wdata_i;
                    if (o == 24) m_lp[c][half*64 +: 64] = m_lp[c][half*64 +: 64] & ~req_wdata_i;
                    if (o >= 512) m_map[c][(o-512)/8 + half*64] = int'(req_wdata_i[2:0]);
                end
                if (off == 2048 + 8)  m_mb0[c] = m_mb0[c] | req_wdata_i;
                if (off == 2048 + 16) m_mb0[c] = m_mb0[c] & ~req_wdata_i;
                if (off == 2048 + 32) m_mb1[c] = m_mb1[c] | req_wdata_i;
                if (off == 2048 + 40) m_mb1[c] = m_mb1[c] & ~req_wdata_i;
            end
            for (int k = 0; k < NC; k++) m_lp[k] = m_lp[k] | link_set_i;
        end
    end

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare against the model every cycle, 5 ns before the rising edge
    always @(negedge clk) begin
        #5;
        if (rst_n) begin
            bit [NC*NL-1:0] ex;
            bit [127:0] st;
            ex = '0;
            for (int c = 0; c < NC; c++) begin
                st = m_stat(c);
                for (int n = 1; n < NS; n++)
                    if (st[n] && m_map[c][n] < NL) ex[c*NL + m_map[c][n]] = 1'b1;
            end
            chk("R7 lines", 64'(irq_o), 64'(ex));
            chk("R11 valid", 64'(rsp_valid_o), 64'(m_rv));
            if (m_rv) chk(m_tag, rsp_rdata_o, m_rd);
        end else begin
            chk("R2 reset lines", 64'(irq_o), 64'd0);
            chk("R2 reset valid", 64'(rsp_valid_o), 64'd0);
        end
    end

    function automatic int A(int cpu, int off);
        return cpu * 4096 + off;
    endfunction

    task automatic cyc(bit wr, bit rd, int a, bit [63:0] d);
        @(negedge clk);
        req_wr_i = wr; req_rd_i = rd; req_addr_i = 14'(a); req_wdata_i = d;
        link_set_i = '0;
    endtask

    task automatic wr(int a, bit [63:0] d); cyc(1, 0, a, d); endtask
    task automatic rd(int a); cyc(0, 1, a, '0); endtask
    task automatic idle(); cyc(0, 0, 0, '0); endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R2: reset values seen through reads
        phase_tag = "R2";
        for (int c = 0; c < NC; c++) begin
            rd(A(c, 'h000)); rd(A(c, 'h400)); rd(A(c, 'h010)); rd(A(c, 'h800));
            rd(A(c, 'h218)); rd(A(c, 'h7F8));
        end
        phase_tag = "";
        // R3 R7: enable source 5 on cpu0, default map to line 0
        wr(A(0, 'h000), ~64'h20);
        @(negedge clk); src_i[5] = 1'b1;
        idle(); rd(A(0, 'h008));
        // R5: remap to line 2, then to code 6 (no line)
        wr(A(0, 'h228), 64'hFFFF_FFF2); rd(A(0, 'h228)); idle();
        wr(A(0, 'h228), 64'd6); idle(); rd(A(0, 'h228));
        wr(A(0, 'h228), 64'd4); idle();
        // R6: source 0 alone is ignored; lower summary appears in upper bit 0
        wr(A(2, 'h000), 64'h0); wr(A(2, 'h400), 64'h0);
        @(negedge clk); src_i = '0; src_i[0] = 1'b1;
        phase_tag = "R6"; rd(A(2, 'h008)); idle();
        @(negedge clk); src_i[70] = 1'b1;
        rd(A(2, 'h008)); rd(A(2, 'h408));
        wr(A(2, 'h630), 64'd3); idle();
        phase_tag = "";
        @(negedge clk); src_i = '0;
        // R8: link pending set in all banks, partial clear, set wins over clear
        link_set_i = '0;
        @(negedge clk); link_set_i[9] = 1'b1; link_set_i[100] = 1'b1; link_set_i[12] = 1'b1;
        @(negedge clk); link_set_i = '0;
        rd(A(1, 'h010)); rd(A(3, 'h410));
        wr(A(1, 'h018), 64'h200);
        rd(A(1, 'h010)); rd(A(0, 'h010));
        @(negedge clk); req_wr_i = 1; req_rd_i = 0; req_addr_i = 14'(A(1, 'h018));
        req_wdata_i = 64'h1000; link_set_i = '0; link_set_i[12] = 1'b1;
        rd(A(1, 'h010)); rd(A(1, 'h018));
        wr(A(1, 'h418), '1); rd(A(1, 'h410));
        // R9: mailbox 0 raises source 26 on cpu3 routed to line 4
        wr(A(3, 'h000), ~(64'd1 << MBS)); wr(A(3, 'h200 + 8*MBS), 64'd4);
        wr(A(3, 'h808), 64'h8000_0000_0000_0001); rd(A(3, 'h800));
        wr(A(3, 'h810), 64'h1); idle(); rd(A(3, 'h800));
        wr(A(3, 'h810), '1); idle(); rd(A(3, 'h800));
        wr(A(3, 'h820), 64'hABCD); rd(A(3, 'h818)); wr(A(3, 'h828), '1); rd(A(3, 'h818));
        rd(A(3, 'h808)); rd(A(3, 'h810));
        // R1: bank isolation
        phase_tag = "R1";
        wr(A(1, 'h000), 64'h1234); rd(A(0, 'h000)); rd(A(1, 'h000)); rd(A(2, 'h000));
        wr(A(1, 'h000) + 5, 64'h55); rd(A(1, 'h007));
        // R10: unmapped and read-only addresses
        phase_tag = "R10";
        wr(A(0, 'h008), '1); wr(A(0, 'h010), '1); wr(A(0, 'h030), '1); wr(A(0, 'hC00), '1);
        wr(A(0, 'h838), '1); wr(A(0, 'h900), '1);
        rd(A(0, 'h030)); rd(A(0, 'hC00)); rd(A(0, 'h838)); rd(A(0, 'h900)); rd(A(0, 'h000));
        rd(A(0, 'h008)); rd(A(0, 'h010)); rd(A(0, 'h018));
        phase_tag = "";
        // R11: simultaneous read and write returns the old value
        @(negedge clk); req_wr_i = 1; req_rd_i = 1; req_addr_i = 14'(A(2, 'h400));
        req_wdata_i = 64'hFFFF; link_set_i = '0;
        rd(A(2, 'h400));
        // mixed traffic
        for (int i = 0; i < 4000; i++) begin
            int c, kind, off;
            c = int'($urandom_range(0, NC-1)); kind = int'($urandom_range(0, 11));
            case (kind)
                0: off = 'h000; 1: off = 'h400; 2: off = 'h008; 3: off = 'h408;
                4: off = 'h010 + 'h400 * int'($urandom_range(0, 1));
                5: off = 'h018 + 'h400 * int'($urandom_range(0, 1));
                6, 7: off = 'h200 + 8 * int'($urandom_range(0, 63)) + 'h400 * int'($urandom_range(0, 1));
                8, 9: off = 'h800 + 8 * int'($urandom_range(0, 5));
                10: off = 'h200 + 8 * MBS;
                default: off = 'h030 + 8 * int'($urandom_range(0, 100));
            endcase
            @(negedge clk);
            req_wr_i = ($urandom_range(0, 2) == 0);
            req_rd_i = ($urandom_range(0, 1) == 0);
            req_addr_i = 14'(A(c, off));
            req_wdata_i = {$urandom, $urandom} & {$urandom, $urandom};
            if (kind == 6 || kind == 7 || kind == 10) req_wdata_i = 64'($urandom_range(0, 7));
            link_set_i = ($urandom_range(0, 7) == 0) ?
                ({$urandom, $urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom, $urandom}) : '0;
            if ($urandom_range(0, 15) == 0)
                src_i = {$urandom, $urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom, $urandom};
        end
        idle(); idle(); idle();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule